// File: doc/BRIEF.md
# Offload Buffer Control Register Bank

This block is the software-facing register bank of a store-and-forward stream buffer controller. It is a 32-bit AXI4-Lite slave. It holds fixed identification and build-configuration words, a scratch word and the run-time controls of the buffer controller. Those controls are oneshot and bypass mode, an active-low software reset, a transfer length, a two-bit synchronization mode and a software sync trigger. It also returns a live snapshot of the controller's status: memory calibration, the state codes of the two state machines, and a 64-bit input beat counter.

Every access is a single 32-bit beat and always completes with an OKAY response. Control outputs and status inputs all live in the bus clock domain. A consumer in a stream clock domain provides its own synchronizers. A write is acted on only when all four byte strobes are set. A write to a read-only or unmapped offset is accepted on the bus and leaves no trace. An unmapped read returns zero.

Top module: `ofl_ctrl_regs`

## Requirements
- R1: After reset: `soft_rst_n`=1; `oneshot_en`, `bypass_en`, `sync_mode` and `sync_trig` are 0; `xfer_len` equals the memory size in bytes divided by 64; `bvalid` and `rvalid` are 0.
- R2: The fixed words read back as follows. Offset 0x00 = {major[31:16], minor[15:8], patch[7:0]}. Offset 0x04 = instance ID. Offset 0x0C = 0x44414F46. Offset 0x10 = {transmit build in bit 1, external memory in bit 0}. Offsets 0x14 and 0x18 hold the 34-bit memory size: 0x14 carries bits 31:0 and 0x18 carries bits 33:32 in its bits 1:0.
- R3: Offset 0x08 is a scratch word; every full-word write to it reads back unchanged.
- R4: A write to a read-only or unmapped offset changes no register and no output. A read of an unmapped offset returns 0.
- R5: A full-word write updates the controls on the edge that accepts it, and each control reads back what was written. The controls are: 0x1C `xfer_len` (32 bits); 0x84 bit 0 `soft_rst_n`; 0x88 bit 1 `oneshot_en` and bit 0 `bypass_en`; 0x104 bits 1:0 `sync_mode`.
- R6: Offset 0x100 bit 0 is `sync_trig`. A write with bit 0 = 1 sets it when it is clear and clears it when it is set. A write with bit 0 = 0 leaves it unchanged. A high `sync_ack` at a clock edge clears it, taking priority over a write in the same cycle. It becomes 1 only after an accepted write.
- R7: Status reads return the inputs as sampled on the edge that accepts the read address. 0x80 bit 0 = `calib_done`. 0x200 = {read state in bits 5:4, write state in bits 1:0}. 0x204 = `beat_cnt[31:0]`. 0x208 = `beat_cnt[63:32]`.
- R8: `awready` and `wready` are high together. They are high exactly when `awvalid` and `wvalid` are both high and no write response is pending. `bvalid` rises on the edge after acceptance, holds until `bready`, and `bresp` is 0.
- R9: `arready` is high while no read data is pending. `rvalid` rises on the edge after acceptance, with `rdata` held stable until `rready`, and `rresp` is 0.
- R10: A write whose `wstrb` is not 4'hF is acknowledged but changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low bus reset |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awaddr | input | ADDR_W | Write byte address |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Write byte strobes |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bresp | output | 2 | Write response, always OKAY |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| araddr | input | ADDR_W | Read byte address |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response, always OKAY |
| soft_rst_n | output | 1 | Software reset to the controller, active low |
| oneshot_en | output | 1 | Play the buffer once |
| bypass_en | output | 1 | Pass-through mode |
| xfer_len | output | 32 | Transfer length in 64-byte units |
| sync_mode | output | 2 | Synchronization mode select |
| sync_trig | output | 1 | Pending software sync trigger |
| sync_ack | input | 1 | Controller has consumed the trigger |
| calib_done | input | 1 | Memory calibration complete |
| rd_state | input | 2 | Output state machine code |
| wr_state | input | 2 | Input state machine code |
| beat_cnt | input | 64 | Input beat counter |

## Verification
A write is due one edge after the handshake. The control outputs change and `bvalid` rises on that edge, so the bench checks them on the falling edge that follows acceptance. Read data is due one edge after the address handshake. The bench checks `rvalid` and `rdata` on that falling edge, holds `rready` low for one more cycle to confirm the data is held, and then releases it. Status inputs are held steady around each read, so the expected word is the value the inputs had when the address was accepted. `sync_ack` is raised for exactly one edge, and the trigger is checked clear on the next falling edge.

// File: rtl/ofl_regs_pkg.sv
package ofl_regs_pkg;
  localparam logic [15:0] OFF_VER   = 16'h0000;
  localparam logic [15:0] OFF_ID    = 16'h0004;
  localparam logic [15:0] OFF_SCR   = 16'h0008;
  localparam logic [15:0] OFF_MAGIC = 16'h000C;
  localparam logic [15:0] OFF_BUILD = 16'h0010;
  localparam logic [15:0] OFF_MLO   = 16'h0014;
  localparam logic [15:0] OFF_MHI   = 16'h0018;
  localparam logic [15:0] OFF_LEN   = 16'h001C;
  localparam logic [15:0] OFF_CAL   = 16'h0080;
  localparam logic [15:0] OFF_SRST  = 16'h0084;
  localparam logic [15:0] OFF_MODE  = 16'h0088;
  localparam logic [15:0] OFF_TRIG  = 16'h0100;
  localparam logic [15:0] OFF_SYNC  = 16'h0104;
  localparam logic [15:0] OFF_FSM   = 16'h0200;
  localparam logic [15:0] OFF_CLO   = 16'h0204;
  localparam logic [15:0] OFF_CHI   = 16'h0208;
  localparam logic [31:0] MAGIC_WORD = 32'h44414F46;

  // word-level address match, byte lanes ignored
  function automatic logic hit(input logic [15:0] a, input logic [15:0] off);
    return a[15:2] == off[15:2];
  endfunction

  function automatic logic [31:0] ver_word(input logic [15:0] mj, input logic [7:0] mn,
                                           input logic [7:0] pt);
    return {mj, mn, pt};
  endfunction

  function automatic logic [31:0] len_default(input logic [33:0] bytes);
    logic [33:0] units;
    units = bytes >> 6;
    return units[31:0];
  endfunction

  function automatic logic [31:0] fsm_word(input logic [1:0] rd, input logic [1:0] wr);
    return {26'd0, rd, 2'd0, wr};
  endfunction
endpackage

// File: rtl/ofl_axil_wr.sv
module ofl_axil_wr #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              wvalid,
  output logic              wready,
  input  logic [31:0]       wdata,
  input  logic [3:0]        wstrb,
  output logic              bvalid,
  input  logic              bready,
  output logic              wr_commit,
  output logic              wr_full,
  output logic [15:0]       wr_addr,
  output logic [31:0]       wr_data
);
  logic take;
  // R8: address and data are accepted together, never with a response pending
  assign take      = awvalid && wvalid && !bvalid;
  assign awready   = take;
  assign wready    = take;
  assign wr_commit = take;
  assign wr_full   = &wstrb;   // R10
  assign wr_addr   = {{(16-ADDR_W){1'b0}}, awaddr};
  assign wr_data   = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bvalid <= 1'b0;
    else if (take)   bvalid <= 1'b1;
    else if (bready) bvalid <= 1'b0;
  end
endmodule

// File: rtl/ofl_axil_rd.sv
module ofl_axil_rd #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ADDR_W-1:0] araddr,
  output logic              rvalid,
  input  logic              rready,
  output logic [31:0]       rdata,
  output logic              rd_take,
  output logic [15:0]       rd_addr,
  input  logic [31:0]       rd_word
);
  // R9: one read outstanding at a time
  assign arready = !rvalid;
  assign rd_take = arvalid && !rvalid;
  assign rd_addr = {{(16-ADDR_W){1'b0}}, araddr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else if (rd_take) begin
      rvalid <= 1'b1;
      rdata  <= rd_word;
    end else if (rready) begin
      rvalid <= 1'b0;
    end
  end
endmodule

// File: rtl/ofl_reg_bank.sv
module ofl_reg_bank
  import ofl_regs_pkg::*;
#(
  parameter logic [15:0] VER_MAJOR = 16'h0001,
  parameter logic [7:0]  VER_MINOR = 8'h02,
  parameter logic [7:0]  VER_PATCH = 8'h00,
  parameter logic [31:0] INST_ID   = 32'h0,
  parameter bit          TX_PATH   = 1'b1,
  parameter bit          EXT_MEM   = 1'b0,
  parameter logic [33:0] MEM_BYTES = 34'd1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_commit,
  input  logic        wr_full,
  input  logic [15:0] wr_addr,
  input  logic [31:0] wr_data,
  input  logic [15:0] rd_addr,
  output logic [31:0] rd_word,
  input  logic        sync_ack,
  input  logic        calib_done,
  input  logic [1:0]  rd_state,
  input  logic [1:0]  wr_state,
  input  logic [63:0] beat_cnt,
  output logic        soft_rst_n,
  output logic        oneshot_en,
  output logic        bypass_en,
  output logic [31:0] xfer_len,
  output logic [1:0]  sync_mode,
  output logic        sync_trig
);
  localparam logic [31:0] LEN_RST = len_default(MEM_BYTES);
  logic [31:0] scratch;
  logic        wr_en;

  assign wr_en = wr_commit && wr_full;  // R10: partial words do nothing

  // R1, R3, R5: writable words; all other offsets fall through (R4)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch    <= '0;
      soft_rst_n <= 1'b1;
      oneshot_en <= 1'b0;
      bypass_en  <= 1'b0;
      xfer_len   <= LEN_RST;
      sync_mode  <= '0;
    end else if (wr_en) begin
      if (hit(wr_addr, OFF_SCR))  scratch    <= wr_data;
      if (hit(wr_addr, OFF_LEN))  xfer_len   <= wr_data;
      if (hit(wr_addr, OFF_SRST)) soft_rst_n <= wr_data[0];
      if (hit(wr_addr, OFF_MODE)) begin
        oneshot_en <= wr_data[1];
        bypass_en  <= wr_data[0];
      end
      if (hit(wr_addr, OFF_SYNC)) sync_mode  <= wr_data[1:0];
    end
  end

  // R6: acknowledge wins, a written 1 toggles the pending trigger
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sync_trig <= 1'b0;
    else if (sync_ack) sync_trig <= 1'b0;
    else if (wr_en && hit(wr_addr, OFF_TRIG) && wr_data[0]) sync_trig <= !sync_trig;
  end

  // R2, R4, R7: read word selection
  always_comb begin
    rd_word = '0;
    if (hit(rd_addr, OFF_VER))   rd_word = ver_word(VER_MAJOR, VER_MINOR, VER_PATCH);
    if (hit(rd_addr, OFF_ID))    rd_word = INST_ID;
    if (hit(rd_addr, OFF_SCR))   rd_word = scratch;
    if (hit(rd_addr, OFF_MAGIC)) rd_word = MAGIC_WORD;
    if (hit(rd_addr, OFF_BUILD)) rd_word = {30'd0, TX_PATH, EXT_MEM};
    if (hit(rd_addr, OFF_MLO))   rd_word = MEM_BYTES[31:0];
    if (hit(rd_addr, OFF_MHI))   rd_word = {30'd0, MEM_BYTES[33:32]};
    if (hit(rd_addr, OFF_LEN))   rd_word = xfer_len;
    if (hit(rd_addr, OFF_CAL))   rd_word = {31'd0, calib_done};
    if (hit(rd_addr, OFF_SRST))  rd_word = {31'd0, soft_rst_n};
    if (hit(rd_addr, OFF_MODE))  rd_word = {30'd0, oneshot_en, bypass_en};
    if (hit(rd_addr, OFF_TRIG))  rd_word = {31'd0, sync_trig};
    if (hit(rd_addr, OFF_SYNC))  rd_word = {30'd0, sync_mode};
    if (hit(rd_addr, OFF_FSM))   rd_word = fsm_word(rd_state, wr_state);
    if (hit(rd_addr, OFF_CLO))   rd_word = beat_cnt[31:0];
    if (hit(rd_addr, OFF_CHI))   rd_word = beat_cnt[63:32];
  end
endmodule

// File: rtl/ofl_ctrl_regs.sv
module ofl_ctrl_regs #(
  parameter int          ADDR_W    = 12,
  parameter logic [15:0] VER_MAJOR = 16'h0001,
  parameter logic [7:0]  VER_MINOR = 8'h02,
  parameter logic [7:0]  VER_PATCH = 8'h00,
  parameter logic [31:0] INST_ID   = 32'h0,
  parameter bit          TX_PATH   = 1'b1,
  parameter bit          EXT_MEM   = 1'b0,
  parameter logic [33:0] MEM_BYTES = 34'd1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              wvalid,
  output logic              wready,
  input  logic [31:0]       wdata,
  input  logic [3:0]        wstrb,
  output logic              bvalid,
  input  logic              bready,
  output logic [1:0]        bresp,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ADDR_W-1:0] araddr,
  output logic              rvalid,
  input  logic              rready,
  output logic [31:0]       rdata,
  output logic [1:0]        rresp,
  output logic              soft_rst_n,
  output logic              oneshot_en,
  output logic              bypass_en,
  output logic [31:0]       xfer_len,
  output logic [1:0]        sync_mode,
  output logic              sync_trig,
  input  logic              sync_ack,
  input  logic              calib_done,
  input  logic [1:0]        rd_state,
  input  logic [1:0]        wr_state,
  input  logic [63:0]       beat_cnt
);
  // named internal events, observed by the checker
  logic        wr_commit, wr_full, rd_take;
  logic [15:0] wr_addr, rd_addr;
  logic [31:0] wr_data, rd_word;

  assign bresp = 2'b00;  // R8
  assign rresp = 2'b00;  // R9

  ofl_axil_wr #(.ADDR_W(ADDR_W)) i_wr (
    .clk(clk), .rst_n(rst_n), .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb),
    .bvalid(bvalid), .bready(bready), .wr_commit(wr_commit), .wr_full(wr_full),
    .wr_addr(wr_addr), .wr_data(wr_data));

  ofl_axil_rd #(.ADDR_W(ADDR_W)) i_rd (
    .clk(clk), .rst_n(rst_n), .arvalid(arvalid), .arready(arready), .araddr(araddr),
    .rvalid(rvalid), .rready(rready), .rdata(rdata), .rd_take(rd_take),
    .rd_addr(rd_addr), .rd_word(rd_word));

  ofl_reg_bank #(
    .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR), .VER_PATCH(VER_PATCH),
    .INST_ID(INST_ID), .TX_PATH(TX_PATH), .EXT_MEM(EXT_MEM), .MEM_BYTES(MEM_BYTES)
  ) i_bank (
    .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit), .wr_full(wr_full),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_word(rd_word),
    .sync_ack(sync_ack), .calib_done(calib_done), .rd_state(rd_state),
    .wr_state(wr_state), .beat_cnt(beat_cnt), .soft_rst_n(soft_rst_n),
    .oneshot_en(oneshot_en), .bypass_en(bypass_en), .xfer_len(xfer_len),
    .sync_mode(sync_mode), .sync_trig(sync_trig));
endmodule

// File: rtl/ofl_ctrl_regs_chk.sv
module ofl_ctrl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        awvalid,
  input logic        wvalid,
  input logic        awready,
  input logic        bvalid,
  input logic        bready,
  input logic        arready,
  input logic        rvalid,
  input logic        rready,
  input logic [31:0] rdata,
  input logic        wr_commit,
  input logic        rd_take,
  input logic        sync_ack,
  input logic        sync_trig,
  input logic [36:0] ctrl_vec
);
  p_b_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && wvalid && awready) |=> bvalid);
  p_b_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid);
  p_no_accept_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> !awready);
  p_r_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |=> rvalid);
  p_r_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rdata)));
  p_ar_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> !arready);
  p_ctrl_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(ctrl_vec));
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ack |=> !sync_trig);
  p_trig_needs_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_trig) |-> $past(wr_commit));
endmodule

bind ofl_ctrl_regs ofl_ctrl_regs_chk i_chk (
  .clk(clk), .rst_n(rst_n), .awvalid(awvalid), .wvalid(wvalid), .awready(awready),
  .bvalid(bvalid), .bready(bready), .arready(arready), .rvalid(rvalid),
  .rready(rready), .rdata(rdata), .wr_commit(wr_commit), .rd_take(rd_take),
  .sync_ack(sync_ack), .sync_trig(sync_trig),
  .ctrl_vec({soft_rst_n, oneshot_en, bypass_en, xfer_len, sync_mode}));

// File: tb/test_ofl_ctrl_regs.sv
module test_ofl_ctrl_regs;
  localparam int AW = 12;
  logic clk = 1'b0, rst_n = 1'b0;
  logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [AW-1:0] awaddr = '0, araddr = '0;
  logic [31:0] wdata = '0;
  logic [3:0] wstrb = '0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata, xfer_len;
  logic soft_rst_n, oneshot_en, bypass_en, sync_trig;
  logic [1:0] sync_mode;
  logic sync_ack = 0, calib_done = 0;
  logic [1:0] rd_state = 0, wr_state = 0;
  logic [63:0] beat_cnt = '0;

  int n_chk = 0, n_fail = 0;
  // bench model of the writable state
  logic [31:0] m_scr = 0, m_len = 32'd16;
  logic m_rst = 1, m_os = 0, m_bp = 0, m_trig = 0;
  logic [1:0] m_mode = 0;

  always #4 clk = !clk;

  ofl_ctrl_regs i_ofl_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb), .bvalid(bvalid),
    .bready(bready), .bresp(bresp), .arvalid(arvalid), .arready(arready),
    .araddr(araddr), .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp),
    .soft_rst_n(soft_rst_n), .oneshot_en(oneshot_en), .bypass_en(bypass_en),
    .xfer_len(xfer_len), .sync_mode(sync_mode), .sync_trig(sync_trig),
    .sync_ack(sync_ack), .calib_done(calib_done), .rd_state(rd_state),
    .wr_state(wr_state), .beat_cnt(beat_cnt));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected read word, from the requirements
  function automatic logic [31:0] exp_rd(input logic [AW-1:0] a);
    case ({a[AW-1:2], 2'b00})
      12'h000: return 32'h0001_0200;
      12'h004: return 32'h0;
      12'h008: return m_scr;
      12'h00C: return 32'h4441_4F46;
      12'h010: return 32'h2;
      12'h014: return 32'd1024;
      12'h018: return 32'h0;
      12'h01C: return m_len;
      12'h080: return {31'd0, calib_done};
      12'h084: return {31'd0, m_rst};
      12'h088: return {30'd0, m_os, m_bp};
      12'h100: return {31'd0, m_trig};
      12'h104: return {30'd0, m_mode};
      12'h200: return {26'd0, rd_state, 2'd0, wr_state};
      12'h204: return beat_cnt[31:0];
      12'h208: return beat_cnt[63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic axi_wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1; bready = 1;
    #1;
    while (!awready) @(negedge clk);
    chk("R8 ready pair", {awready, wready}, 2'b11);
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    chk("R8 bvalid after accept", {bvalid, bresp}, 3'b100);
    @(negedge clk);
    chk("R8 bvalid released", bvalid, 0);
    bready = 0;
  endtask

  task automatic axi_rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    araddr = a; arvalid = 1; rready = 0;
    #1;
    while (!arready) @(negedge clk);
    @(negedge clk);
    arvalid = 0;
    d = rdata;
    chk("R9 rvalid after accept", {rvalid, arready, rresp}, 4'b1000);
    @(negedge clk);
    chk("R9 rdata held", {rvalid, rdata}, {1'b1, d});
    rready = 1;
    @(negedge clk);
    chk("R9 rvalid released", rvalid, 0);
    rready = 0;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a);
    logic [31:0] d;
    logic [31:0] e;
    e = exp_rd(a);
    axi_rd(a, d);
    chk(req, d, e);
  endtask

  task automatic out_chk(input string req);
    chk(req, {soft_rst_n, oneshot_en, bypass_en, xfer_len, sync_mode, sync_trig},
        {m_rst, m_os, m_bp, m_len, m_mode, m_trig});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset outputs", {soft_rst_n, oneshot_en, bypass_en, xfer_len, sync_mode,
        sync_trig, bvalid, rvalid}, {1'b1, 1'b0, 1'b0, 32'd16, 2'b00, 1'b0, 1'b0, 1'b0});
    rst_n = 1;
    // R2: fixed words
    rd_chk("R2 version", 12'h000);
    rd_chk("R2 id", 12'h004);
    rd_chk("R2 magic", 12'h00C);
    rd_chk("R2 build", 12'h010);
    rd_chk("R2 size low", 12'h014);
    rd_chk("R2 size high", 12'h018);
    rd_chk("R1 length reset", 12'h01C);
    // R4: writes to read-only offsets and unmapped space are dropped
    axi_wr(12'h00C, 32'hFFFF_FFFF, 4'hF);
    axi_wr(12'h018, 32'h3, 4'hF);
    axi_wr(12'h300, 32'hFFFF_FFFF, 4'hF);
    out_chk("R4 outputs after ignored writes");
    rd_chk("R4 magic after write", 12'h00C);
    rd_chk("R4 size high after write", 12'h018);
    rd_chk("R4 unmapped read", 12'h300);
    // R10: partial strobe
    axi_wr(12'h008, 32'h1234_5678, 4'h7);
    rd_chk("R10 partial write to scratch", 12'h008);
    axi_wr(12'h088, 32'h3, 4'hE);
    out_chk("R10 partial write to mode");
    // R6: trigger toggle, ack priority
    axi_wr(12'h100, 32'h1, 4'hF); m_trig = 1;
    out_chk("R6 trigger armed");
    rd_chk("R6 trigger readback", 12'h100);
    axi_wr(12'h100, 32'h0, 4'hF);
    out_chk("R6 zero write keeps trigger");
    axi_wr(12'h100, 32'h1, 4'hF); m_trig = 0;
    out_chk("R6 one write cancels trigger");
    axi_wr(12'h100, 32'h1, 4'hF); m_trig = 1;
    @(negedge clk); sync_ack = 1;
    @(negedge clk); sync_ack = 0; m_trig = 0;
    out_chk("R6 ack clears trigger");
    // R6: ack at the same edge as a write of 1 wins
    @(negedge clk);
    awaddr = 12'h100; wdata = 1; wstrb = 4'hF; awvalid = 1; wvalid = 1; bready = 1;
    sync_ack = 1;
    @(negedge clk);
    awvalid = 0; wvalid = 0; sync_ack = 0;
    @(negedge clk); bready = 0;
    out_chk("R6 ack beats write");
    // R3, R5: random writes to the writable words
    for (int i = 0; i < 60; i++) begin
      int sel;
      logic [31:0] v;
      sel = int'($urandom % 5);
      v = $urandom;
      case (sel)
        0: begin axi_wr(12'h008, v, 4'hF); m_scr = v; rd_chk("R3 scratch", 12'h008); end
        1: begin axi_wr(12'h01C, v, 4'hF); m_len = v; rd_chk("R5 length", 12'h01C); end
        2: begin axi_wr(12'h084, v, 4'hF); m_rst = v[0]; rd_chk("R5 soft reset", 12'h084); end
        3: begin axi_wr(12'h088, v, 4'hF); m_os = v[1]; m_bp = v[0]; rd_chk("R5 mode", 12'h088); end
        default: begin axi_wr(12'h104, v, 4'hF); m_mode = v[1:0]; rd_chk("R5 sync mode", 12'h104); end
      endcase
      out_chk("R5 outputs");
    end
    // R7: status snapshots
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      calib_done = 1'($urandom); rd_state = 2'($urandom); wr_state = 2'($urandom);
      beat_cnt = {$urandom, $urandom};
      rd_chk("R7 calibration", 12'h080);
      rd_chk("R7 state codes", 12'h200);
      rd_chk("R7 count low", 12'h204);
      rd_chk("R7 count high", 12'h208);
    end
    // R4: random unmapped reads and writes
    for (int i = 0; i < 10; i++) begin
      logic [AW-1:0] a;
      a = 12'h400 + 12'(($urandom % 64) * 4);
      axi_wr(a, $urandom, 4'hF);
      rd_chk("R4 random unmapped", a);
      out_chk("R4 outputs after unmapped write");
    end
    rd_chk("R3 scratch final", 12'h008);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule